// File: doc/BRIEF.md
# USB Host Bus Power-State Controller

This block keeps the bus-level power and line state of a USB host port. Software writes a small control register to request suspend, to drive resume or bus reset signalling, and to allow high-speed negotiation. From those bits and from two inputs, the block decides when the frame counter and the transaction scheduler may run. The first input says that a transaction is still in flight. The second says that the PHY has seen resume signalling from the attached device.

A suspend request does not cut a transaction short. The block stops the scheduler from starting new work at once, waits until the in-flight transaction ends, and only then enters the suspended state. In that state it may ask the PHY to go to low power. A remote wake-up seen while suspended has three effects: the block leaves suspend, sets its own resume bit so that it goes on driving resume on the line, and latches a sticky interrupt that can be masked. Software times the resume and reset pulses. Once it clears either bit, frame generation and scheduling start again.

Top module: `usb_host_pwr_ctrl`

## Requirements
- R1: The control register sits at address 0. Bit 0 enables PHY low power in suspend, bit 1 requests suspend, bit 2 is resume, bit 3 is bus reset, bit 4 is the high-speed-mode status and bit 5 enables high speed. Bit 4 ignores writes, and bits above 5 read as 0. A read returns data on `reg_rdata` one cycle after `reg_rd`.
- R2: Once the suspend bit is set, `sched_en` and `sof_en` are low from the next cycle on.
- R3: While `xfer_busy` is high, a pending suspend does not enter the suspended state and `phy_suspend` stays low. The suspended state is entered at the first clock edge that samples `xfer_busy` low.
- R4: `phy_suspend` is high one cycle after the suspended state is entered, and only if bit 0 is set.
- R5: `drive_resume` follows the resume bit with one cycle of delay. The scheduler is held off while the bit is set, and it restarts one cycle after the bit is cleared.
- R6: A high `phy_resume_det` in the suspended state leaves suspend at that edge. It clears the suspend bit, sets the resume bit and drops `phy_suspend` one cycle later. Outside the suspended state it has no effect.
- R7: The interrupt status sits at address 1, bit 0. It is sticky, it is set by a remote wake-up and it is cleared by a read of that address. The enable sits at address 2, bit 0. `irq` is status AND enable, registered.
- R8: `drive_reset` follows the reset bit with one cycle of delay. While reset is set, the suspend and resume bits are forced to 0.
- R9: While reset and high-speed enable are both set, a high `chirp_ok` sets the high-speed-mode status. With high-speed enable clear, `chirp_ok` has no effect.
- R10: A write that sets the reset bit while it was clear also clears the high-speed-mode status.
- R11: Clearing the reset bit makes `sched_en` and `sof_en` high one cycle later, provided no suspend or resume is set.
- R12: While `rst` is high, every output and register is 0. The first clock after release raises `sched_en` and `sof_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| xfer_busy | input | 1 | Scheduler has a transaction in flight |
| phy_resume_det | input | 1 | PHY sees resume signalling from the device |
| chirp_ok | input | 1 | High-speed handshake succeeded during reset |
| sched_en | output | 1 | Transaction scheduler may run |
| sof_en | output | 1 | Frame counter and SOF generation may run |
| phy_suspend | output | 1 | PHY low-power request |
| drive_resume | output | 1 | Drive resume signalling on the bus |
| drive_reset | output | 1 | Drive reset signalling on the bus |
| irq | output | 1 | Resume interrupt |

## Verification
A register write takes effect at its clock edge E. `drive_resume`, `drive_reset` and the gating of `sched_en` by register bits are due at E+1. A change of the power state lands at E+1, and `phy_suspend` follows it at E+2. The same two-cycle delay applies to a restart after software clears suspend from the suspended state. A remote wake-up sampled at edge W shows up in the outputs and `irq` at W+1, and read data is due one cycle after the read strobe. The bench drives and samples on the falling edge. Each check steps the exact number of falling edges given by these latencies, and around each transition it checks both the cycle before the change and the cycle of the change.

// File: rtl/usb_pwr_pkg.sv
package usb_pwr_pkg;
  localparam int CTRL_W = 6;

  localparam int B_PHYLP  = 0;
  localparam int B_SUSP   = 1;
  localparam int B_RESUME = 2;
  localparam int B_RESET  = 3;
  localparam int B_HSMODE = 4;
  localparam int B_HSEN   = 5;

  localparam int A_CTRL     = 0;
  localparam int A_IRQ_STAT = 1;
  localparam int A_IRQ_EN   = 2;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_DRAIN = 2'd1,
    PS_SUSP  = 2'd2
  } pwr_state_e;

  // packed MSB first so the struct matches the register bit layout
  typedef struct packed {
    logic hs_en;
    logic hs_mode;
    logic reset;
    logic resume;
    logic susp;
    logic phy_lp;
  } ctrl_t;
endpackage

// File: rtl/usb_pwr_regs.sv
module usb_pwr_regs
  import usb_pwr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              wake,
  input  logic              chirp_ok,
  output ctrl_t             ctrl,
  output logic              irq_stat,
  output logic              irq_en
);
  generate
    if (DATA_W < CTRL_W) begin : g_bad_width
      $error("DATA_W must hold the control register");
    end
  endgenerate

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:CTRL_W];

  logic  sel_ctrl, sel_stat, sel_en;
  logic  wr_ctrl, rd_stat;
  ctrl_t ctrl_nxt;
  logic  stat_nxt;
  logic [DATA_W-1:0] rd_mux;

  assign sel_ctrl = (addr == ADDR_W'(A_CTRL));
  assign sel_stat = (addr == ADDR_W'(A_IRQ_STAT));
  assign sel_en   = (addr == ADDR_W'(A_IRQ_EN));
  assign wr_ctrl  = wr_en && sel_ctrl;
  assign rd_stat  = rd_en && sel_stat;

  always_comb begin
    ctrl_nxt = ctrl;
    if (wr_ctrl) begin
      ctrl_nxt.phy_lp = wdata[B_PHYLP];
      ctrl_nxt.susp   = wdata[B_SUSP];
      ctrl_nxt.resume = wdata[B_RESUME];
      ctrl_nxt.reset  = wdata[B_RESET];
      ctrl_nxt.hs_en  = wdata[B_HSEN];
    end
    if (wake) begin
      ctrl_nxt.resume = 1'b1;
      ctrl_nxt.susp   = 1'b0;
    end
    if (ctrl_nxt.reset) begin
      ctrl_nxt.susp   = 1'b0;
      ctrl_nxt.resume = 1'b0;
    end
    if (wr_ctrl && wdata[B_RESET] && !ctrl.reset)
      ctrl_nxt.hs_mode = 1'b0;
    else if (ctrl.reset && ctrl.hs_en && chirp_ok)
      ctrl_nxt.hs_mode = 1'b1;
  end

  always_comb begin
    if (wake)         stat_nxt = 1'b1;
    else if (rd_stat) stat_nxt = 1'b0;
    else              stat_nxt = irq_stat;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)      rd_mux = DATA_W'(ctrl);
    else if (sel_stat) rd_mux = DATA_W'(irq_stat);
    else if (sel_en)   rd_mux = DATA_W'(irq_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      irq_stat <= 1'b0;
      irq_en   <= 1'b0;
      rdata    <= '0;
    end else begin
      ctrl     <= ctrl_nxt;
      irq_stat <= stat_nxt;
      if (wr_en && sel_en) irq_en <= wdata[0];
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R8: reset bit excludes suspend and resume
  assert_reset_cancel_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl.reset |-> (!ctrl.susp && !ctrl.resume));

  // R10: a fresh reset starts with the speed status clear
  assert_hs_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl.reset) |-> !ctrl.hs_mode);

  // R7: status holds until read
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_stat && !rd_stat) |=> irq_stat);
endmodule

// File: rtl/usb_pwr_fsm.sv
module usb_pwr_fsm
  import usb_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctrl_t      ctrl,
  input  logic       xfer_busy,
  input  logic       phy_resume_det,
  output pwr_state_e state,
  output logic       wake
);
  pwr_state_e nxt;

  assign wake = (state == PS_SUSP) && phy_resume_det && !ctrl.reset;

  always_comb begin
    nxt = state;
    case (state)
      PS_RUN: begin
        if (ctrl.susp && !ctrl.reset)
          nxt = xfer_busy ? PS_DRAIN : PS_SUSP;
      end
      PS_DRAIN: begin
        if (!ctrl.susp || ctrl.reset) nxt = PS_RUN;
        else if (!xfer_busy)          nxt = PS_SUSP;
      end
      PS_SUSP: begin
        if (wake || !ctrl.susp || ctrl.reset) nxt = PS_RUN;
      end
      default: nxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PS_RUN;
    else     state <= nxt;
  end

  // R3: a busy bus never lets suspend be entered
  assert_no_susp_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (state != PS_SUSP && xfer_busy) |=> (state != PS_SUSP));

  // R6: wake-up always returns to running
  assert_wake_exit_R6: assert property (@(posedge clk) disable iff (rst)
    wake |=> (state == PS_RUN));
endmodule

// File: rtl/usb_pwr_out.sv
module usb_pwr_out
  import usb_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pwr_state_e state,
  input  ctrl_t      ctrl,
  input  logic       irq_stat,
  input  logic       irq_en,
  output logic       sched_en,
  output logic       sof_en,
  output logic       phy_suspend,
  output logic       drive_resume,
  output logic       drive_reset,
  output logic       irq
);
  logic run_ok;

  assign run_ok = (state == PS_RUN) && !ctrl.susp && !ctrl.resume && !ctrl.reset;

  always_ff @(posedge clk) begin
    if (rst) begin
      sched_en     <= 1'b0;
      sof_en       <= 1'b0;
      phy_suspend  <= 1'b0;
      drive_resume <= 1'b0;
      drive_reset  <= 1'b0;
      irq          <= 1'b0;
    end else begin
      sched_en     <= run_ok;
      sof_en       <= run_ok;
      phy_suspend  <= (state == PS_SUSP) && ctrl.phy_lp;
      drive_resume <= ctrl.resume;
      drive_reset  <= ctrl.reset;
      irq          <= irq_stat && irq_en;
    end
  end

  // R8: never drive reset and resume together
  assert_drive_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(drive_reset && drive_resume));

  // R7: interrupt only with its enable
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));
endmodule

// File: rtl/usb_host_pwr_ctrl.sv
module usb_host_pwr_ctrl
  import usb_pwr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xfer_busy,
  input  logic              phy_resume_det,
  input  logic              chirp_ok,
  output logic              sched_en,
  output logic              sof_en,
  output logic              phy_suspend,
  output logic              drive_resume,
  output logic              drive_reset,
  output logic              irq
);
  ctrl_t      ctrl;
  pwr_state_e state;
  logic       wake;
  logic       irq_stat, irq_en;

  usb_pwr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .wake(wake), .chirp_ok(chirp_ok),
    .ctrl(ctrl), .irq_stat(irq_stat), .irq_en(irq_en)
  );

  usb_pwr_fsm u_fsm (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .xfer_busy(xfer_busy), .phy_resume_det(phy_resume_det),
    .state(state), .wake(wake)
  );

  usb_pwr_out u_out (
    .clk(clk), .rst(rst), .state(state), .ctrl(ctrl),
    .irq_stat(irq_stat), .irq_en(irq_en),
    .sched_en(sched_en), .sof_en(sof_en), .phy_suspend(phy_suspend),
    .drive_resume(drive_resume), .drive_reset(drive_reset), .irq(irq)
  );

  logic wr_ctrl;
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(A_CTRL));

  // R2: a set suspend bit stops the scheduler next cycle
  assert_sched_off_susp_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl.susp |=> !sched_en);

  // R4: PHY low power needs its enable
  assert_phy_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !ctrl.phy_lp |=> !phy_suspend);

  // R6: wake-up hands resume drive to the block
  assert_wake_resume_R6: assert property (@(posedge clk) disable iff (rst)
    (wake && !wr_ctrl) |=> (ctrl.resume && !ctrl.susp));
endmodule

// File: tb/usb_host_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module usb_host_pwr_ctrl_bench;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic xfer_busy = 1'b0, phy_resume_det = 1'b0, chirp_ok = 1'b0;
  logic sched_en, sof_en, phy_suspend, drive_resume, drive_reset, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usb_host_pwr_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u_usb_host_pwr_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_busy(xfer_busy), .phy_resume_det(phy_resume_det), .chirp_ok(chirp_ok),
    .sched_en(sched_en), .sof_en(sof_en), .phy_suspend(phy_suspend),
    .drive_resume(drive_resume), .drive_reset(drive_reset), .irq(irq)
  );

  // expected readback of the control register after a plain write
  function automatic logic [7:0] exp_ctrl(input logic [7:0] w, input logic hs);
    logic [7:0] r;
    r = w & 8'h2F;
    if (r[3]) r[2:1] = 2'b00;
    r[4] = hs;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = AW'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_wake();
    phy_resume_det = 1'b1;
    @(negedge clk);
    phy_resume_det = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_0042));
    step(3);
    // R12: reset state
    chk("R12 outputs in reset", {sched_en, sof_en, phy_suspend, drive_resume, drive_reset, irq}, 0);
    chk("R12 rdata in reset", reg_rdata, 0);
    rst = 1'b0;
    step(1);
    chk("R12 sched after release", {sched_en, sof_en}, 2'b11);
    rd(0, d); chk("R12 ctrl zero", d, 0);

    // R1: layout, bit 4 read-only, upper bits zero
    wr(0, 8'h31); rd(0, d); chk("R1 bit4 ignored", d, exp_ctrl(8'h31, 1'b0));
    wr(0, 8'hC1); rd(0, d); chk("R1 upper bits zero", d, 8'h01);
    wr(0, 8'h00); step(1);

    // R2/R4: suspend while idle, PHY low power disabled
    wr(0, 8'h02); step(1);
    chk("R2 sched off", {sched_en, sof_en}, 2'b00);
    step(1); chk("R4 no lp without enable", phy_suspend, 0);
    wr(0, 8'h00); step(1);
    chk("R2 restart not yet", sched_en, 0);
    step(1); chk("R2 restart after suspend", {sched_en, sof_en}, 2'b11);

    // R7 enable, then R3 drain with busy
    wr(2, 8'h01);
    xfer_busy = 1'b1;
    wr(0, 8'h03); step(1);
    chk("R2 sched off while drain", sched_en, 0);
    step(3); chk("R3 no suspend while busy", phy_suspend, 0);
    xfer_busy = 1'b0;
    step(1); chk("R3 lp one cycle after entry", phy_suspend, 0);
    step(1); chk("R4 lp after entry", phy_suspend, 1);

    // R6/R7 remote wake-up
    pulse_wake(); step(1);
    chk("R6 phy leaves lp", phy_suspend, 0);
    chk("R6 resume driven", drive_resume, 1);
    chk("R5 sched held by resume", sched_en, 0);
    chk("R7 irq raised", irq, 1);
    rd(0, d); chk("R6 ctrl after wake", d, 8'h05);
    rd(1, d); chk("R7 status read", d, 8'h01);
    step(1); chk("R7 irq cleared by read", irq, 0);
    rd(1, d); chk("R7 status clear", d, 8'h00);

    // R5 clearing resume restarts
    wr(0, 8'h01); step(1);
    chk("R5 resume off", drive_resume, 0);
    chk("R5 sched restart", {sched_en, sof_en}, 2'b11);
    wr(0, 8'h04); step(1);
    chk("R5 resume driven", drive_resume, 1);
    chk("R5 sched held", sched_en, 0);
    wr(0, 8'h00); step(1);

    // R6 wake outside suspend ignored
    pulse_wake(); step(1);
    chk("R6 ignored resume", drive_resume, 0);
    chk("R6 ignored irq", irq, 0);
    rd(0, d); chk("R6 ignored ctrl", d, 8'h00);
    rd(1, d); chk("R6 ignored status", d, 8'h00);

    // R8 reset cancels suspend and resume
    wr(0, 8'h02); step(3);
    wr(0, 8'h0A); step(1);
    chk("R8 reset driven", drive_reset, 1);
    chk("R8 no resume", drive_resume, 0);
    rd(0, d); chk("R8 suspend cancelled", d, 8'h08);
    wr(0, 8'h0C); rd(0, d); chk("R8 resume masked", d, 8'h08);
    step(1); chk("R8 resume not driven", drive_resume, 0);

    // R9/R11 high-speed negotiation
    wr(0, 8'h28);
    chirp_ok = 1'b1; step(1); chirp_ok = 1'b0;
    rd(0, d); chk("R9 hs set", d, 8'h38);
    wr(0, 8'h20); step(1);
    chk("R11 reset off", drive_reset, 0);
    chk("R11 sched restart", {sched_en, sof_en}, 2'b11);
    rd(0, d); chk("R9 hs kept", d, 8'h30);

    // R10 new reset clears status; R9 no hs without enable
    wr(0, 8'h28); rd(0, d); chk("R10 hs cleared", d, 8'h28);
    wr(0, 8'h08);
    chirp_ok = 1'b1; step(1); chirp_ok = 1'b0;
    rd(0, d); chk("R9 no hs without enable", d, 8'h08);
    wr(0, 8'h00); step(1);

    // random suspend / drain / wake rounds
    for (int i = 0; i < 24; i++) begin
      logic lp, en;
      int blen;
      lp   = 1'($urandom_range(0, 1));
      en   = 1'($urandom_range(0, 1));
      blen = int'($urandom_range(0, 4));
      wr(2, {7'd0, en});
      xfer_busy = (blen > 0);
      wr(0, {6'd0, 1'b1, lp});
      for (int k = 0; k < blen; k++) begin
        step(1); chk("R3 random drain", phy_suspend, 0);
      end
      xfer_busy = 1'b0;
      step(2); chk("R4 random lp", phy_suspend, lp);
      pulse_wake(); step(1);
      chk("R6 random resume", {drive_resume, phy_suspend}, 2'b10);
      chk("R7 random irq", irq, en);
      rd(1, d); chk("R7 random status", d, 8'h01);
      wr(0, 8'h00); step(1);
      chk("R5 random restart", sched_en, 1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule